// File: doc/BRIEF.md
# Cache flush command controller

This block takes flush commands aimed at a descriptor cache and runs them one at a time. A flush command carries a 16-bit tag, a flag that asks for a completion record, a 40-bit descriptor address and several control bits. The control bits can ask the block to:

- hand the address's queue contents onward first;
- keep the cache line valid after writing it out;
- flush the whole cache;
- free one of four address-blocking slots;
- claim one of the four slots for the address.

A second, narrower command port frees a single slot or lifts a whole-cache block.

The cache, the queue forwarder and the descriptor memory are outside this block. It reaches them through two request/done handshakes: one for forwarding and one for the flush itself. An access-check port lets other logic ask whether an address may be used right now. Each command can end with a one-cycle status record that echoes the tag and carries an error flag.

Top module: `flush_cmd_ctrl`

## Requirements
- R1: After reset, both command ports are ready, all four slots are free, the whole cache is unblocked, and `fwdReq`, `flushReq` and `stValid` are low.
- R2: A command is accepted when its valid and ready signals are both high. Both ready signals then stay low until the block returns to idle. When both ports present a command at once, the flush port wins and `unbReady` is low.
- R3: A flush command with the release bit set that selects a free slot is rejected. It issues no forward and no flush, leaves every slot unchanged, and reports error = 1.
- R4: A flush command with the block bit set, the release bit clear, and a selected slot that is already held is rejected in the same way: no flush, no slot change, error = 1.
- R5: A flush command with both the release and block bits set, on a held slot, frees that slot and then claims it again for the new address. It reports error = 0.
- R6: A successful flush with the block bit set records `cmdAddr` in the slot chosen by `cmdSlot` (values 0 to 3). From the cycle after the flush completes, `accBlocked` is 1 for that address and stays 1 until the slot is freed.
- R7: While `flushReq` is high, `flushAddr` equals the command address. `flushInval` is 0 when the keep-line bit is set and 1 otherwise.
- R8: A whole-cache flush ignores the forward, release, block, keep-line and slot fields. It raises `flushReq` with `flushAll` = 1 and `flushInval` = 1. It leaves all slot states unchanged. From completion onward, `accBlocked` is 1 for every address until a whole-cache unblock arrives.
- R9: With the forward bit set on a non-whole flush, `fwdReq` is raised first. `flushReq` rises only after `fwdDone` has been seen, and the two requests are never high together.
- R10: A status record, `stValid` high for exactly one cycle with `stNum` equal to the command's tag, is produced only when the status-required bit was 1.
- R11: An unblock command frees the selected slot and reports error = 0. Selecting a free slot reports error = 1. The whole-cache type lifts the whole-cache block and never reports an error.
- R12: `accBlocked` follows `accAddr` in the same cycle. During a claiming flush it reflects the slots after any release but before the claim, which takes effect at the edge where `flushDone` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Flush command present |
| cmdReady | output | 1 | Flush command accepted this cycle if valid |
| cmdNum | input | 16 | Flush command tag |
| cmdStatusReq | input | 1 | 1 = produce a status record |
| cmdAddr | input | 40 | Descriptor address to flush |
| cmdForward | input | 1 | Forward queue contents before flushing |
| cmdRelease | input | 1 | Free the selected slot first |
| cmdSlot | input | 2 | Blocking slot index 0..3 |
| cmdKeepLine | input | 1 | Write out but keep the line valid |
| cmdBlock | input | 1 | Claim the selected slot for the address |
| cmdWholeCache | input | 1 | Flush the entire cache |
| unbValid | input | 1 | Unblock command present |
| unbReady | output | 1 | Unblock command accepted this cycle if valid |
| unbNum | input | 16 | Unblock command tag |
| unbStatusReq | input | 1 | 1 = produce a status record |
| unbWholeCache | input | 1 | 1 = lift whole-cache block, 0 = free a slot |
| unbSlot | input | 2 | Slot to free |
| fwdReq | output | 1 | Queue forwarding request |
| fwdDone | input | 1 | Queue forwarding finished |
| flushReq | output | 1 | Flush request toward the cache |
| flushDone | input | 1 | Flush finished |
| flushAddr | output | 40 | Address being flushed |
| flushInval | output | 1 | Invalidate the line after writing it out |
| flushAll | output | 1 | Flush covers the whole cache |
| accAddr | input | 40 | Address to test for blocking |
| accBlocked | output | 1 | Address may not be used |
| stValid | output | 1 | Status record valid |
| stNum | output | 16 | Echoed command tag |
| stErr | output | 1 | Command was rejected |

## Verification
Two things can land on the same slot in the same command: the release and the claim. The bench drives a model-guided sweep of every slot under every combination of release, block, keep-line and forward bits, so each slot passes through held and free states with both bits set. Directed cases then add the held-without-release rejection, and the bench model predicts every status error.

The access check also overlaps with flush completion. The probe address is held on the command's own address for the whole command. It is sampled in the cycle `flushReq` is first seen, where it must show only the released state. It is sampled again after `flushDone`, where it must show the claim.

// File: rtl/flush_cmd_pkg.sv
package flush_cmd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_FWD,
    S_FLUSH,
    S_STATUS
  } ctl_state_e;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic loadFlush;   // capture a flush command
    logic loadUnb;     // capture an unblock command
    logic markErr;     // command rejected
    logic doRelease;   // apply the release part of a flush command
    logic doUnblock;   // apply an unblock command
    logic doFinish;    // flush finished: claim slot or block whole cache
  } strobe_t;

endpackage

// File: rtl/flush_cmd_dp.sv
module flush_cmd_dp
  import flush_cmd_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int NUM_W  = 16,
  parameter int SLOTS  = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [NUM_W-1:0]  cmdNum,
  input  logic              cmdStatusReq,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdForward,
  input  logic              cmdRelease,
  input  logic [SLOT_W-1:0] cmdSlot,
  input  logic              cmdKeepLine,
  input  logic              cmdBlock,
  input  logic              cmdWholeCache,
  input  logic [NUM_W-1:0]  unbNum,
  input  logic              unbStatusReq,
  input  logic              unbWholeCache,
  input  logic [SLOT_W-1:0] unbSlot,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              isUnb,
  output logic              isWhole,
  output logic              wantFwd,
  output logic              wantStatus,
  output logic              chkErr,
  output logic              errFlag,
  output logic [NUM_W-1:0]  numOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic              invalOut,
  output logic              accBlocked
);

  logic [NUM_W-1:0]  numQ;
  logic [ADDR_W-1:0] addrQ;
  logic [SLOT_W-1:0] slotQ;
  logic sreqQ, unbQ, wholeQ, fwdQ, relQ, keepQ, blkQ, errQ;

  logic [SLOTS-1:0]  held, heldNext;
  logic [ADDR_W-1:0] slotAddr [SLOTS];
  logic [SLOTS-1:0]  hit;
  logic              wholeBlk;
  logic              curHeld;

  // command register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      numQ <= '0; addrQ <= '0; slotQ <= '0;
      sreqQ <= 1'b0; unbQ <= 1'b0; wholeQ <= 1'b0; fwdQ <= 1'b0;
      relQ <= 1'b0; keepQ <= 1'b0; blkQ <= 1'b0; errQ <= 1'b0;
    end else begin
      if (stb.loadFlush) begin
        numQ <= cmdNum; sreqQ <= cmdStatusReq; addrQ <= cmdAddr;
        slotQ <= cmdSlot; unbQ <= 1'b0; wholeQ <= cmdWholeCache;
        fwdQ <= cmdForward; relQ <= cmdRelease; keepQ <= cmdKeepLine;
        blkQ <= cmdBlock; errQ <= 1'b0;
      end else if (stb.loadUnb) begin
        numQ <= unbNum; sreqQ <= unbStatusReq; slotQ <= unbSlot;
        unbQ <= 1'b1; wholeQ <= unbWholeCache;
        fwdQ <= 1'b0; relQ <= 1'b0; keepQ <= 1'b0; blkQ <= 1'b0;
        errQ <= 1'b0;
      end
      if (stb.markErr) errQ <= 1'b1;
    end
  end

  // whole-cache block flag
  always_ff @(posedge clk) begin
    if (!rstN) wholeBlk <= 1'b0;
    else if (stb.doFinish && wholeQ && !unbQ) wholeBlk <= 1'b1;
    else if (stb.doUnblock && wholeQ) wholeBlk <= 1'b0;
  end

  // slot state: release first, then claim
  always_comb begin
    heldNext = held;
    for (int s = 0; s < SLOTS; s++) begin
      if (slotQ == SLOT_W'(s) && !wholeQ) begin
        if ((stb.doRelease && relQ) || stb.doUnblock) heldNext[s] = 1'b0;
        if (stb.doFinish && blkQ) heldNext[s] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      held <= '0;
      for (int s = 0; s < SLOTS; s++) slotAddr[s] <= '0;
    end else begin
      held <= heldNext;
      for (int s = 0; s < SLOTS; s++)
        if (stb.doFinish && blkQ && !wholeQ && slotQ == SLOT_W'(s))
          slotAddr[s] <= addrQ;
    end
  end

  // parallel address compare across all slots
  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign hit[g] = held[g] && (slotAddr[g] == accAddr);
  end

  assign accBlocked = wholeBlk || (|hit);
  assign curHeld    = held[slotQ];

  // rejection rules; whole-cache commands never fail
  always_comb begin
    if (wholeQ)    chkErr = 1'b0;
    else if (unbQ) chkErr = !curHeld;
    else           chkErr = (relQ && !curHeld) || (blkQ && curHeld && !relQ);
  end

  assign isUnb      = unbQ;
  assign isWhole    = wholeQ;
  assign wantFwd    = fwdQ && !wholeQ;
  assign wantStatus = sreqQ;
  assign errFlag    = errQ;
  assign numOut     = numQ;
  assign addrOut    = addrQ;
  assign invalOut   = wholeQ || !keepQ;

endmodule

// File: rtl/flush_cmd_fsm.sv
module flush_cmd_fsm
  import flush_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic    unbValid,
  input  logic    fwdDone,
  input  logic    flushDone,
  input  logic    chkErr,
  input  logic    isUnb,
  input  logic    wantFwd,
  input  logic    wantStatus,
  output logic    cmdReady,
  output logic    unbReady,
  output logic    fwdReq,
  output logic    flushReq,
  output logic    stValid,
  output strobe_t stb
);

  ctl_state_e st, stNext, doneState;

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext    = st;
    stb       = '0;
    cmdReady  = 1'b0;
    unbReady  = 1'b0;
    fwdReq    = 1'b0;
    flushReq  = 1'b0;
    stValid   = 1'b0;
    doneState = wantStatus ? S_STATUS : S_IDLE;
    unique case (st)
      S_IDLE: begin
        cmdReady = 1'b1;
        unbReady = !cmdValid;
        if (cmdValid) begin
          stb.loadFlush = 1'b1;
          stNext = S_CHECK;
        end else if (unbValid) begin
          stb.loadUnb = 1'b1;
          stNext = S_CHECK;
        end
      end
      S_CHECK: begin
        if (chkErr) begin
          stb.markErr = 1'b1;
          stNext = doneState;
        end else if (isUnb) begin
          stb.doUnblock = 1'b1;
          stNext = doneState;
        end else begin
          stb.doRelease = 1'b1;
          stNext = wantFwd ? S_FWD : S_FLUSH;
        end
      end
      S_FWD: begin
        fwdReq = 1'b1;
        if (fwdDone) stNext = S_FLUSH;
      end
      S_FLUSH: begin
        flushReq = 1'b1;
        if (flushDone) begin
          stb.doFinish = 1'b1;
          stNext = doneState;
        end
      end
      S_STATUS: begin
        stValid = 1'b1;
        stNext  = S_IDLE;
      end
      default: stNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/flush_cmd_ctrl.sv
module flush_cmd_ctrl
  import flush_cmd_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int NUM_W  = 16,
  parameter int SLOTS  = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [NUM_W-1:0]  cmdNum,
  input  logic              cmdStatusReq,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdForward,
  input  logic              cmdRelease,
  input  logic [SLOT_W-1:0] cmdSlot,
  input  logic              cmdKeepLine,
  input  logic              cmdBlock,
  input  logic              cmdWholeCache,
  input  logic              unbValid,
  output logic              unbReady,
  input  logic [NUM_W-1:0]  unbNum,
  input  logic              unbStatusReq,
  input  logic              unbWholeCache,
  input  logic [SLOT_W-1:0] unbSlot,
  output logic              fwdReq,
  input  logic              fwdDone,
  output logic              flushReq,
  input  logic              flushDone,
  output logic [ADDR_W-1:0] flushAddr,
  output logic              flushInval,
  output logic              flushAll,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              accBlocked,
  output logic              stValid,
  output logic [NUM_W-1:0]  stNum,
  output logic              stErr
);

  strobe_t stb;
  logic isUnb, isWhole, wantFwd, wantStatus, chkErr;

  flush_cmd_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .unbValid   (unbValid),
    .fwdDone    (fwdDone),
    .flushDone  (flushDone),
    .chkErr     (chkErr),
    .isUnb      (isUnb),
    .wantFwd    (wantFwd),
    .wantStatus (wantStatus),
    .cmdReady   (cmdReady),
    .unbReady   (unbReady),
    .fwdReq     (fwdReq),
    .flushReq   (flushReq),
    .stValid    (stValid),
    .stb        (stb)
  );

  flush_cmd_dp #(.ADDR_W(ADDR_W), .NUM_W(NUM_W), .SLOTS(SLOTS)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .cmdNum        (cmdNum),
    .cmdStatusReq  (cmdStatusReq),
    .cmdAddr       (cmdAddr),
    .cmdForward    (cmdForward),
    .cmdRelease    (cmdRelease),
    .cmdSlot       (cmdSlot),
    .cmdKeepLine   (cmdKeepLine),
    .cmdBlock      (cmdBlock),
    .cmdWholeCache (cmdWholeCache),
    .unbNum        (unbNum),
    .unbStatusReq  (unbStatusReq),
    .unbWholeCache (unbWholeCache),
    .unbSlot       (unbSlot),
    .accAddr       (accAddr),
    .isUnb         (isUnb),
    .isWhole       (isWhole),
    .wantFwd       (wantFwd),
    .wantStatus    (wantStatus),
    .chkErr        (chkErr),
    .errFlag       (stErr),
    .numOut        (stNum),
    .addrOut       (flushAddr),
    .invalOut      (flushInval),
    .accBlocked    (accBlocked)
  );

  assign flushAll = flushReq && isWhole;

endmodule

// File: rtl/flush_cmd_chk.sv
module flush_cmd_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic              unbReady,
  input logic              fwdReq,
  input logic              flushReq,
  input logic              flushDone,
  input logic [ADDR_W-1:0] flushAddr,
  input logic              flushAll,
  input logic              flushInval,
  input logic              stValid
);

  // R9
  fwd_flush_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fwdReq && flushReq));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  // R2
  unb_yield_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !unbReady);

  // R10
  status_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    stValid |=> !stValid);

  // R10
  status_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stValid |-> !cmdReady);

  // R8
  whole_inval_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |-> (flushReq && flushInval));

  // R7
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && !flushDone) |=> (flushReq && $stable(flushAddr)));

endmodule

bind flush_cmd_ctrl flush_cmd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .cmdReady   (cmdReady),
  .unbReady   (unbReady),
  .fwdReq     (fwdReq),
  .flushReq   (flushReq),
  .flushDone  (flushDone),
  .flushAddr  (flushAddr),
  .flushAll   (flushAll),
  .flushInval (flushInval),
  .stValid    (stValid)
);

// File: tb/sim_flush_cmd_ctrl.sv
module sim_flush_cmd_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 0, cmdStatusReq = 0, cmdForward = 0, cmdRelease = 0;
  logic cmdKeepLine = 0, cmdBlock = 0, cmdWholeCache = 0;
  logic [15:0] cmdNum = '0, unbNum = '0;
  logic [39:0] cmdAddr = '0, accAddr = '0;
  logic [1:0]  cmdSlot = '0, unbSlot = '0;
  logic unbValid = 0, unbStatusReq = 0, unbWholeCache = 0;
  logic fwdDone = 0, flushDone = 0;
  logic cmdReady, unbReady, fwdReq, flushReq, flushInval, flushAll;
  logic accBlocked, stValid, stErr;
  logic [39:0] flushAddr;
  logic [15:0] stNum;

  always #(CLK_P/2) clk = ~clk;

  flush_cmd_ctrl u0 (.*);

  int nChk = 0, nBad = 0;
  bit heldM [4];
  logic [39:0] addrM [4];
  bit wholeM = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit probeM(input logic [39:0] a);
    bit r = wholeM;
    for (int s = 0; s < 4; s++) if (heldM[s] && addrM[s] == a) r = 1;
    return r;
  endfunction

  // runs one command through the design and checks the observed sequence
  task automatic runCmd(input bit isUnb, input logic [15:0] num, input bit sreq,
                        input logic [39:0] a, input bit fwd, input bit rel,
                        input logic [1:0] slot, input bit keep, input bit blk,
                        input bit whole, input bit expErr, input bit expFlush,
                        input bit expFwd, input bit expMid);
    bit sawFlush = 0, sawFwd = 0, fwdGiven = 0, orderBad = 0, midV = 0;
    bit fInval = 0, fAll = 0, gotErr = 0, done = 0;
    logic [39:0] fAddr = '0;
    logic [15:0] gotNum = '0;
    int stCnt = 0;
    @(negedge clk);
    if (isUnb) begin
      unbValid = 1; unbNum = num; unbStatusReq = sreq;
      unbWholeCache = whole; unbSlot = slot;
    end else begin
      cmdValid = 1; cmdNum = num; cmdStatusReq = sreq; cmdAddr = a;
      cmdForward = fwd; cmdRelease = rel; cmdSlot = slot;
      cmdKeepLine = keep; cmdBlock = blk; cmdWholeCache = whole;
    end
    accAddr = a;
    @(negedge clk);
    cmdValid = 0; unbValid = 0;
    check(!cmdReady && !unbReady, "R2", "ready low after accept",
          {cmdReady, unbReady}, 0);
    for (int k = 0; k < 40; k++) begin
      if (cmdReady) begin done = 1; break; end
      fwdDone = 0; flushDone = 0;
      if (flushReq) begin
        if (!sawFlush) begin
          midV = accBlocked; fInval = flushInval; fAll = flushAll; fAddr = flushAddr;
          if (expFwd && !fwdGiven) orderBad = 1;
        end
        sawFlush = 1; flushDone = 1;
      end
      if (fwdReq) begin sawFwd = 1; fwdDone = 1; fwdGiven = 1; end
      if (stValid) begin stCnt++; gotNum = stNum; gotErr = stErr; end
      @(negedge clk);
    end
    fwdDone = 0; flushDone = 0;
    check(done, "R2", "returned to idle", done, 1);
    check(stCnt == int'(sreq), "R10", "status count", stCnt, sreq);
    if (sreq) begin
      check(gotNum == num, "R10", "status tag", gotNum, num);
      check(gotErr == expErr, expErr ? "R3/R4/R11" : "R5/R11", "status error", gotErr, expErr);
    end
    check(sawFlush == expFlush, "R3", "flush issued", sawFlush, expFlush);
    check(sawFwd == expFwd, "R9", "forward issued", sawFwd, expFwd);
    check(!orderBad, "R9", "flush before forward done", orderBad, 0);
    if (expFlush) begin
      check(fAll == whole, "R8", "flushAll", fAll, whole);
      check(fInval == (whole || !keep), "R7", "flushInval", fInval, whole || !keep);
      if (!whole) check(fAddr == a, "R7", "flushAddr", fAddr, a);
      check(midV == expMid, "R12", "access check during flush", midV, expMid);
    end
  endtask

  task automatic flushStep(input logic [15:0] num, input bit sreq, input logic [39:0] a,
                           input bit fwd, input bit rel, input logic [1:0] slot,
                           input bit keep, input bit blk);
    bit err = (rel && !heldM[slot]) || (blk && heldM[slot] && !rel);
    if (!err && rel) heldM[slot] = 0;
    runCmd(0, num, sreq, a, fwd, rel, slot, keep, blk, 0, err, !err, !err && fwd, probeM(a));
    if (!err && blk) begin heldM[slot] = 1; addrM[slot] = a; end
  endtask

  task automatic unbStep(input logic [15:0] num, input bit sreq, input bit whole,
                         input logic [1:0] slot);
    bit err = !whole && !heldM[slot];
    if (!err) begin
      if (whole) wholeM = 0; else heldM[slot] = 0;
    end
    runCmd(1, num, sreq, 40'h0, 0, 0, slot, 0, 0, whole, err, 0, 0, 0);
  endtask

  task automatic probeAll(input string req);
    for (int s = 0; s < 4; s++) begin
      accAddr = addrM[s]; #1;
      check(accBlocked == probeM(addrM[s]), req, "slot address probe", accBlocked, probeM(addrM[s]));
    end
    accAddr = 40'hFF_FFFF_FFFF; #1;
    check(accBlocked == wholeM, req, "unused address probe", accBlocked, wholeM);
  endtask

  initial begin
    #(CLK_P * 150000);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) begin heldM[s] = 0; addrM[s] = 40'h0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    check(cmdReady && unbReady, "R1", "ready after reset", {cmdReady, unbReady}, 3);
    check(!fwdReq && !flushReq && !stValid, "R1", "requests idle",
          {fwdReq, flushReq, stValid}, 0);
    accAddr = 40'h0; #1;
    check(!accBlocked, "R1", "nothing blocked", accBlocked, 0);

    // R2 arbitration between the two ports
    cmdValid = 1; unbValid = 1; #1;
    check(!unbReady && cmdReady, "R2", "flush port priority", {cmdReady, unbReady}, 2);
    cmdValid = 0; unbValid = 0; #1;

    // sweep: slot, block, release, keep-line, forward (R5 R6 R7 R9 R12)
    for (int i = 0; i < 64; i++) begin
      logic [5:0] b = 6'(i);
      flushStep(16'(i * 257 + 5), (i % 3) != 0,
                40'h2A_0000_0000 + 40'(i) * 40'h10_0101,
                b[5], b[3], b[1:0], b[4], b[2]);
      probeAll("R6");
    end

    // directed slot sequences on slot 2
    if (heldM[2]) unbStep(16'h0101, 1, 0, 2);
    flushStep(16'h0200, 1, 40'h55_0000_1000, 0, 0, 2, 0, 1); // claim, R6
    probeAll("R6");
    flushStep(16'h0201, 1, 40'h55_0000_2000, 0, 0, 2, 0, 1); // R4 held, no release
    probeAll("R4");
    flushStep(16'h0202, 1, 40'h55_0000_3000, 1, 1, 2, 1, 1); // R5 release+claim
    probeAll("R5");
    flushStep(16'h0203, 1, 40'h55_0000_4000, 0, 1, 2, 0, 0); // release ok
    flushStep(16'h0204, 1, 40'h55_0000_5000, 0, 1, 2, 0, 0); // R3 free slot
    probeAll("R3");

    // whole-cache flush with junk control bits (R8)
    flushStep(16'h0300, 1, 40'h66_0000_0100, 0, 0, 0, 0, 1);
    if (!heldM[1]) flushStep(16'h0301, 0, 40'h66_0000_0200, 0, 0, 1, 0, 1);
    runCmd(0, 16'h0302, 1, 40'h77_0000_0000, 1, 1, 0, 1, 1, 1, 0, 1, 0,
           probeM(40'h77_0000_0000));
    wholeM = 1;
    probeAll("R8");
    unbStep(16'h0303, 1, 1, 0);                               // R11 whole unblock
    probeAll("R8");

    // unblock of slots (R11)
    for (int s = 0; s < 4; s++) begin
      unbStep(16'(16'h0400 + s), 1, 0, 2'(s));
      unbStep(16'(16'h0410 + s), 1, 0, 2'(s));               // second is on a free slot
      probeAll("R11");
    end

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule